// File: doc/BRIEF.md
# Multiplexed Latched Bus Exchanger

This block joins one 12-bit A bus to two 12-bit B buses, called B1 and B2, through four level-sensitive storage banks. Toward the B side, the word on A is kept in two separate banks, one feeding B1 and one feeding B2. With these two banks, a stream of A words can be split across the two B buses. Toward the A side, each B bus has its own capture bank, and a select input chooses which bank feeds A. With these two banks, two B streams can be merged onto A.

Every port is modelled as three separate signals: a data input, a data output and a drive-enable output, and no tristate pins are used. Each port has an active-low output enable. The two B-side enables also serve as bank controls, so B1 and B2 can be driven one at a time or together. An active-low reset clears all four banks and turns off every driver. Typical uses are address/data demultiplexing and memory interleaving.

Top module: `bus_exchanger`

## Requirements
- R1: While `rstN` is 0, all three drive-enable outputs are 0, all data outputs are 0 and all four banks are cleared. After release, any port that is then enabled while its bank stays closed reads 0.
- R2: While `openToB1` is 1 and `b1EnN` is 0, `b1DrvEn` is 1 and `b1Out` follows `aIn` in the same time step.
- R3: While `openToB2` is 1 and `b2EnN` is 0, `b2DrvEn` is 1 and `b2Out` follows `aIn` in the same time step.
- R4: When `openToB1` or `openToB2` falls, that bank keeps the `aIn` value it last passed until its open signal returns to 1. Later changes on `aIn` do not reach the port.
- R5: With `aEnN` at 0, `aDrvEn` is 1. When `pickB1` is 1, `aOut` shows the B1 capture bank; when `pickB1` is 0, it shows the B2 capture bank. An open bank passes its B input through in the same time step.
- R6: When `openFromB1` or `openFromB2` falls, that bank holds its value while its B input goes on changing. Switching `pickB1` selects between the two held values.
- R7: An output enable at 1 forces that port's drive-enable to 0 and its data output to 0. The banks go on opening and holding while their port is disabled, and they show what they captured once the port is enabled again.
- R8: The B1 and B2 enables act independently. Both B ports can be driven at the same time, each with a different captured word.
- R9: If a bank's open signal falls in the same time step as its data input changes, the bank keeps the value it held before that time step. This applies to all four banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Active-low reset; clears all banks and disables all drivers |
| aIn | input | W | Data arriving on the A bus |
| aOut | output | W | Data driven onto the A bus (0 when disabled) |
| aDrvEn | output | 1 | A bus driver enable |
| b1In | input | W | Data arriving on the B1 bus |
| b1Out | output | W | Data driven onto the B1 bus (0 when disabled) |
| b1DrvEn | output | 1 | B1 bus driver enable |
| b2In | input | W | Data arriving on the B2 bus |
| b2Out | output | W | Data driven onto the B2 bus (0 when disabled) |
| b2DrvEn | output | 1 | B2 bus driver enable |
| openToB1 | input | 1 | Opens the A-to-B1 bank; it holds while this is 0 |
| openToB2 | input | 1 | Opens the A-to-B2 bank; it holds while this is 0 |
| openFromB1 | input | 1 | Opens the B1-to-A bank; it holds while this is 0 |
| openFromB2 | input | 1 | Opens the B2-to-A bank; it holds while this is 0 |
| aEnN | input | 1 | Active-low output enable for the A port |
| b1EnN | input | 1 | Active-low output enable for the B1 port |
| b2EnN | input | 1 | Active-low output enable for the B2 port |
| pickB1 | input | 1 | 1 selects the B1 capture bank onto A; 0 selects the B2 bank |

## Verification
The assertions sample the ports combinationally, so they assume that all inputs changing in one time step settle before any output is checked. They also assume that the only way a bank is cleared is through `rstN`. The bench meets both assumptions: it changes every input in a single burst just after a rising clock edge and reads the outputs at the next falling edge. The same-step capture case is also produced inside one such burst, which keeps the order of the closing enable and the data change well defined.

// File: rtl/bx_pkg.sv
package bx_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic openToB1;
    logic openToB2;
    logic openFromB1;
    logic openFromB2;
    logic driveA;
    logic driveB1;
    logic driveB2;
    logic pickB1;
  } bx_strobe_t;
endpackage

// File: rtl/bx_latch_bank.sv
module bx_latch_bank #(
  parameter int W = 12
) (
  input  logic         clear,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Transparent while open, holds otherwise; clear has priority
  always_latch begin
    if (clear)     q <= '0;
    else if (open) q <= d;
  end
endmodule

// File: rtl/bx_ctrl.sv
module bx_ctrl
  import bx_pkg::*;
(
  input  logic       rstN,
  input  logic       openToB1,
  input  logic       openToB2,
  input  logic       openFromB1,
  input  logic       openFromB2,
  input  logic       aEnN,
  input  logic       b1EnN,
  input  logic       b2EnN,
  input  logic       pickB1,
  output bx_strobe_t strobe
);
  logic live;

  always_comb begin
    live              = rstN;
    strobe.clear      = !live;
    strobe.openToB1   = live && openToB1;
    strobe.openToB2   = live && openToB2;
    strobe.openFromB1 = live && openFromB1;
    strobe.openFromB2 = live && openFromB2;
    strobe.driveA     = live && !aEnN;
    strobe.driveB1    = live && !b1EnN;
    strobe.driveB2    = live && !b2EnN;
    strobe.pickB1     = pickB1;
  end
endmodule

// File: rtl/bx_datapath.sv
module bx_datapath
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  bx_strobe_t   strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] b1In,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] aOut,
  output logic [W-1:0] b1Out,
  output logic [W-1:0] b2Out
);
  localparam int NUM_B = 2;

  logic [W-1:0] bInArr   [NUM_B];
  logic [W-1:0] toBQ     [NUM_B];
  logic [W-1:0] fromBQ   [NUM_B];
  logic [NUM_B-1:0] openTo;
  logic [NUM_B-1:0] openFrom;
  logic [W-1:0] aSel;

  assign bInArr[0] = b1In;
  assign bInArr[1] = b2In;
  assign openTo    = {strobe.openToB2, strobe.openToB1};
  assign openFrom  = {strobe.openFromB2, strobe.openFromB1};

  for (genvar g = 0; g < NUM_B; g++) begin : g_bank
    bx_latch_bank #(.W(W)) i_toB (
      .clear (strobe.clear),
      .open  (openTo[g]),
      .d     (aIn),
      .q     (toBQ[g])
    );
    bx_latch_bank #(.W(W)) i_fromB (
      .clear (strobe.clear),
      .open  (openFrom[g]),
      .d     (bInArr[g]),
      .q     (fromBQ[g])
    );
  end

  always_comb begin
    aSel  = strobe.pickB1 ? fromBQ[0] : fromBQ[1];
    aOut  = strobe.driveA  ? aSel    : '0;
    b1Out = strobe.driveB1 ? toBQ[0] : '0;
    b2Out = strobe.driveB2 ? toBQ[1] : '0;
  end
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         rstN,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic         aDrvEn,
  input  logic [W-1:0] b1In,
  output logic [W-1:0] b1Out,
  output logic         b1DrvEn,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] b2Out,
  output logic         b2DrvEn,
  input  logic         openToB1,
  input  logic         openToB2,
  input  logic         openFromB1,
  input  logic         openFromB2,
  input  logic         aEnN,
  input  logic         b1EnN,
  input  logic         b2EnN,
  input  logic         pickB1
);
  bx_strobe_t strobe;

  bx_ctrl i_ctrl (
    .rstN       (rstN),
    .openToB1   (openToB1),
    .openToB2   (openToB2),
    .openFromB1 (openFromB1),
    .openFromB2 (openFromB2),
    .aEnN       (aEnN),
    .b1EnN      (b1EnN),
    .b2EnN      (b2EnN),
    .pickB1     (pickB1),
    .strobe     (strobe)
  );

  bx_datapath #(.W(W)) i_dp (
    .strobe (strobe),
    .aIn    (aIn),
    .b1In   (b1In),
    .b2In   (b2In),
    .aOut   (aOut),
    .b1Out  (b1Out),
    .b2Out  (b2Out)
  );

  assign aDrvEn  = strobe.driveA;
  assign b1DrvEn = strobe.driveB1;
  assign b2DrvEn = strobe.driveB2;
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
  parameter int W = 12
) (
  input logic         rstN,
  input logic [W-1:0] aIn,
  input logic [W-1:0] aOut,
  input logic         aDrvEn,
  input logic [W-1:0] b1In,
  input logic [W-1:0] b1Out,
  input logic         b1DrvEn,
  input logic [W-1:0] b2In,
  input logic [W-1:0] b2Out,
  input logic         b2DrvEn,
  input logic         openToB1,
  input logic         openToB2,
  input logic         openFromB1,
  input logic         openFromB2,
  input logic         aEnN,
  input logic         b1EnN,
  input logic         b2EnN,
  input logic         pickB1
);
  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!aDrvEn && !b1DrvEn && !b2DrvEn && aOut == '0 && b1Out == '0 && b2Out == '0); // R1
    end else begin
      if (openToB1 && !b1EnN)
        AST_B1_FOLLOWS_A: assert (b1DrvEn && b1Out == aIn); // R2
      if (openToB2 && !b2EnN)
        AST_B2_FOLLOWS_A: assert (b2DrvEn && b2Out == aIn); // R3
      if (!aEnN && pickB1 && openFromB1)
        AST_A_FOLLOWS_B1: assert (aDrvEn && aOut == b1In); // R5
      if (!aEnN && !pickB1 && openFromB2)
        AST_A_FOLLOWS_B2: assert (aDrvEn && aOut == b2In); // R5
      if (aEnN)
        AST_A_OFF_ZERO: assert (!aDrvEn && aOut == '0); // R7
      if (b1EnN)
        AST_B1_OFF_ZERO: assert (!b1DrvEn && b1Out == '0); // R7
      if (b2EnN)
        AST_B2_OFF_ZERO: assert (!b2DrvEn && b2Out == '0); // R7
    end
  end
endmodule

bind bus_exchanger bx_checker #(.W(W)) i_bx_checker (.*);

// File: tb/test_bus_exchanger.sv
module test_bus_exchanger;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rstN;
  logic [W-1:0] aIn, b1In, b2In, aOut, b1Out, b2Out;
  logic         aDrvEn, b1DrvEn, b2DrvEn;
  logic         openToB1, openToB2, openFromB1, openFromB2;
  logic         aEnN, b1EnN, b2EnN, pickB1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bus_exchanger #(.W(W)) i_bus_exchanger (.*);

  typedef struct packed {
    logic [3:0]   open;   // {toB1,toB2,fromB1,fromB2}
    logic [2:0]   enN;    // {a,b1,b2}
    logic         pick;
    logic [W-1:0] a, b1, b2;
    logic [W-1:0] expA, expB1, expB2;
    logic [2:0]   expDrv; // {a,b1,b2}
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 3'b000, 1'b1, 12'hABC, 12'h123, 12'h456, 12'h000, 12'h000, 12'h000, 3'b111}, // R1 banks zero
    '{4'b1000, 3'b101, 1'b1, 12'hABC, 12'h123, 12'h456, 12'h000, 12'hABC, 12'h000, 3'b010}, // R2
    '{4'b1000, 3'b101, 1'b1, 12'hDEF, 12'h123, 12'h456, 12'h000, 12'hDEF, 12'h000, 3'b010}, // R2
    '{4'b0000, 3'b101, 1'b1, 12'h111, 12'h123, 12'h456, 12'h000, 12'hDEF, 12'h000, 3'b010}, // R4
    '{4'b0100, 3'b110, 1'b1, 12'h222, 12'h123, 12'h456, 12'h000, 12'h000, 12'h222, 3'b001}, // R3 R7
    '{4'b0000, 3'b100, 1'b1, 12'h333, 12'h123, 12'h456, 12'h000, 12'hDEF, 12'h222, 3'b011}, // R4 R8
    '{4'b0010, 3'b011, 1'b1, 12'h333, 12'h5A5, 12'h456, 12'h5A5, 12'h000, 12'h000, 3'b100}, // R5
    '{4'b0000, 3'b011, 1'b1, 12'h333, 12'h777, 12'h456, 12'h5A5, 12'h000, 12'h000, 3'b100}, // R6
    '{4'b0001, 3'b011, 1'b0, 12'h333, 12'h777, 12'h0F0, 12'h0F0, 12'h000, 12'h000, 3'b100}, // R5
    '{4'b0000, 3'b011, 1'b1, 12'h333, 12'h777, 12'h999, 12'h5A5, 12'h000, 12'h000, 3'b100}, // R6
    '{4'b0000, 3'b011, 1'b0, 12'h333, 12'h777, 12'h999, 12'h0F0, 12'h000, 12'h000, 3'b100}, // R6
    '{4'b1111, 3'b111, 1'b1, 12'hAAA, 12'hBBB, 12'hCCC, 12'h000, 12'h000, 12'h000, 3'b000}, // R7
    '{4'b0000, 3'b000, 1'b1, 12'h000, 12'h000, 12'h000, 12'hBBB, 12'hAAA, 12'hAAA, 3'b111}  // R7 R8
  };

  task automatic check(input string req, input logic [3*W+2:0] act, input logic [3*W+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3*W+2:0] observed();
    return {aOut, b1Out, b2Out, aDrvEn, b1DrvEn, b2DrvEn};
  endfunction

  task automatic drive(input logic [3:0] op, input logic [2:0] en, input logic pk,
                       input logic [W-1:0] a, input logic [W-1:0] b1, input logic [W-1:0] b2);
    {openToB1, openToB2, openFromB1, openFromB2} = op;
    {aEnN, b1EnN, b2EnN} = en;
    pickB1 = pk;
    aIn = a; b1In = b1; b2In = b2;
  endtask

  // Open one bank on v1, then close it while data moves to v2 in the same step
  task automatic sameStep(input int bank);
    logic [3:0]   op;
    logic [2:0]   en;
    logic         pk;
    logic [3*W+2:0] exp;
    logic [W-1:0] v1, v2;
    v1 = 12'h3C0 + 12'(bank);
    v2 = 12'hC03 - 12'(bank);
    op = 4'b1000 >> bank;
    en = (bank == 0) ? 3'b101 : (bank == 1) ? 3'b110 : 3'b011;
    pk = (bank != 3);
    case (bank)
      0: exp = {12'h000, v1, 12'h000, 3'b010};
      1: exp = {12'h000, 12'h000, v1, 3'b001};
      default: exp = {v1, 12'h000, 12'h000, 3'b100};
    endcase
    @(posedge clk);
    drive(op, en, pk, v1, v1, v1);
    @(negedge clk);
    @(posedge clk);
    drive(4'b0000, en, pk, v2, v2, v2);
    @(negedge clk);
    check("R9 same-step capture", observed(), exp);
  endtask

  initial begin
    rstN = 1'b0;
    drive(4'b1111, 3'b000, 1'b1, 12'hFFF, 12'hFFF, 12'hFFF);
    @(negedge clk);
    check("R1 during reset", observed(), '0);
    @(posedge clk);
    drive(4'b0000, 3'b000, 1'b1, 12'hABC, 12'h123, 12'h456);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      drive(VECS[i].open, VECS[i].enN, VECS[i].pick, VECS[i].a, VECS[i].b1, VECS[i].b2);
      @(negedge clk);
      check($sformatf("vector %0d (R1..)", i), observed(),
            {VECS[i].expA, VECS[i].expB1, VECS[i].expB2, VECS[i].expDrv});
    end

    for (int b = 0; b < 4; b++) sameStep(b);

    // R1: reset wipes held data
    @(posedge clk);
    drive(4'b1111, 3'b111, 1'b1, 12'h765, 12'h765, 12'h765);
    @(posedge clk);
    drive(4'b0000, 3'b000, 1'b1, 12'h000, 12'h000, 12'h000);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset asserted", observed(), '0);
    @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 banks cleared", observed(), {36'h0, 3'b111});

    // R8: both B ports at once with distinct words
    @(posedge clk);
    drive(4'b1000, 3'b111, 1'b1, 12'h1A1, 12'h0, 12'h0);
    @(posedge clk);
    drive(4'b0100, 3'b111, 1'b1, 12'h2B2, 12'h0, 12'h0);
    @(posedge clk);
    drive(4'b0000, 3'b100, 1'b1, 12'h000, 12'h0, 12'h0);
    @(negedge clk);
    check("R8 dual B drive", observed(), {12'h000, 12'h1A1, 12'h2B2, 3'b011});

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule